// File: doc/BRIEF.md
# Width-Limited In-Order Retirement Controller

This block decides, once per cycle, how many entries at the head of a reorder buffer may leave it. It looks at a window of the oldest entries of the currently selected thread. It walks that window from the oldest entry to the youngest and stops at the first entry that cannot leave. Each entry carries a small flag set. The controller uses those flags and a global "stores still draining" input to choose what to do with each slot. The slot can commit, be dropped as a squashed entry, stall, or hand a request back to the execution side. The possible requests are a non-speculative execution request, an uncached load replay, or a trap.

The decision path is purely combinational from the head window to the strobes. A surrounding pipeline can therefore pop the buffer on the same clock edge. Three counters and a per-thread trap-pending state are the only registers. A thread whose trap is pending is not allowed to retire until the trap sequencer clears it.

Top module: `retire_ctrl`

## Requirements
- R1: Slots are examined oldest first (slot 0 is the oldest). Examination stops at the first slot that is invalid or not ready. Nothing retires when `sel_valid_i` is low or when the selected thread has its trap-pending bit set.
- R2: A ready squashed slot (flag bit 1) is removed through `retire_o` without setting `commit_o`. It does not use up a commit position. It adds one to `squash_count_o`.
- R3: A ready executed slot (flag bit 0) with no fault commits and examination continues. A slot with the no-op flag (bit 6) still commits but is not added to `insn_count_o`.
- R4: A ready unexecuted slot flagged non-speculative (bit 3) or barrier (bit 4) can proceed only when no commit has happened yet this cycle and `stores_pending_i` is low. When it proceeds, it raises `nonspec_req_o` with its sequence number and sets its bit in `canc_clr_o`. Otherwise it stalls silently. In both cases examination stops.
- R5: A ready unexecuted load (bit 5) that is not non-speculative or barrier raises `uncached_req_o` with its sequence number and sets its `canc_clr_o` bit. This happens whatever its position or the store state, and examination stops.
- R6: A ready executed slot with the fault flag (bit 2) raises `trap_req_o` only when no commit has happened yet this cycle and no stores are pending. Otherwise it stalls. A trap sets the selected thread's `trap_pending_o` bit on the next edge. A `trap_clear_i` bit clears it, and a new trap wins over a clear.
- R7: A ready unexecuted slot with none of the non-speculative, barrier or load flags raises `bad_head_o` and stops examination.
- R8: `bwlimit_count_o` increments on every cycle in which the number of commits equals the window width.
- R9: After reset all counters and trap-pending bits are zero.
- R10: At most one of `nonspec_req_o`, `uncached_req_o`, `trap_req_o`, `bad_head_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid_i | input | 1 | A thread is selected for retirement this cycle |
| sel_tid_i | input | TID_W | Selected thread |
| stores_pending_i | input | 1 | Stores still awaiting writeback |
| head_valid_i | input | WIDTH | Slot holds an entry |
| head_ready_i | input | WIDTH | Slot entry may be considered (can-commit) |
| head_flags_i | input | WIDTH*7 | Per-slot flags: 0 executed, 1 squashed, 2 fault, 3 non-spec, 4 barrier, 5 load, 6 no-op |
| head_seq_i | input | WIDTH*SEQ_W | Per-slot sequence numbers |
| trap_clear_i | input | THREADS | Clear trap-pending per thread |
| retire_o | output | WIDTH | Slot leaves the buffer |
| commit_o | output | WIDTH | Slot commits architecturally |
| canc_clr_o | output | WIDTH | Clear can-commit of this slot |
| nonspec_req_o | output | 1 | Non-speculative execution request |
| nonspec_seq_o | output | SEQ_W | Its sequence number |
| uncached_req_o | output | 1 | Uncached load replay request |
| uncached_seq_o | output | SEQ_W | Its sequence number |
| trap_req_o | output | 1 | Trap request |
| trap_tid_o | output | TID_W | Thread of the trap |
| bad_head_o | output | 1 | Unexecuted slot of unknown kind |
| trap_pending_o | output | THREADS | Per-thread trap pending |
| insn_count_o | output | CNT_W | Committed non-no-op instructions |
| squash_count_o | output | CNT_W | Squashed entries removed |
| bwlimit_count_o | output | CNT_W | Cycles at full commit width |

## Verification
Commits of older slots and the stopping decision of a younger slot happen in the same cycle. Whether that decision becomes a request depends on how many commits came before it in that cycle. The bench provokes this in several ways. It places non-speculative, load and faulting entries behind zero, one or more committed or squashed entries, with and without pending stores. It then checks that the load still issues its replay, while the non-speculative and faulting entries stall unless they are first. A behavioural model computes the expected strobes and counters slot by slot and is compared with the design every cycle, both in directed cases and in a long random stream.

// File: rtl/retire_ctrl_pkg.sv
package retire_ctrl_pkg;

  typedef struct packed {
    logic nop;
    logic load;
    logic barrier;
    logic nonspec;
    logic fault;
    logic squashed;
    logic executed;
  } head_flags_t;

  localparam int FLAG_W = $bits(head_flags_t);

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_COMMIT,
    ACT_DROP,
    ACT_NONSPEC,
    ACT_UNCACHED,
    ACT_TRAP,
    ACT_BAD,
    ACT_STALL
  } slot_act_e;

  function automatic logic first_position(input int unsigned used);
    return used == 0;
  endfunction

endpackage

// File: rtl/retire_slot_decide.sv
module retire_slot_decide
  import retire_ctrl_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic        live_i,
  input  logic        valid_i,
  input  logic        ready_i,
  input  head_flags_t flags_i,
  input  logic [CW-1:0] used_i,
  input  logic        stores_i,
  output slot_act_e   act_o,
  output logic        tally_o,
  output logic        live_o,
  output logic [CW-1:0] used_o
);

  logic at_front;
  assign at_front = first_position(int'(used_i)) && !stores_i;

  always_comb begin
    act_o   = ACT_IDLE;
    live_o  = 1'b0;
    used_o  = used_i;
    tally_o = 1'b0;
    if (live_i) begin
      if (!valid_i || !ready_i) begin
        act_o = ACT_STALL;
      end else if (flags_i.squashed) begin
        act_o  = ACT_DROP;
        live_o = 1'b1;
      end else if (!flags_i.executed) begin
        if (flags_i.nonspec || flags_i.barrier) begin
          act_o = at_front ? ACT_NONSPEC : ACT_STALL;
        end else if (flags_i.load) begin
          act_o = ACT_UNCACHED;
        end else begin
          act_o = ACT_BAD;
        end
      end else if (flags_i.fault) begin
        act_o = at_front ? ACT_TRAP : ACT_STALL;
      end else begin
        act_o   = ACT_COMMIT;
        live_o  = 1'b1;
        used_o  = used_i + 1'b1;
        tally_o = !flags_i.nop;
      end
    end
  end

endmodule

// File: rtl/retire_trap_state.sv
module retire_trap_state #(
  parameter int THREADS = 2,
  parameter int TID_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic [TID_W-1:0]   tid_i,
  input  logic [THREADS-1:0] clear_i,
  output logic [THREADS-1:0] pending_o
);

  logic [THREADS-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      for (int t = 0; t < THREADS; t++) begin
        if (set_i && int'(tid_i) == t) pend_q[t] <= 1'b1;
        else if (clear_i[t])           pend_q[t] <= 1'b0;
      end
    end
  end

  assign pending_o = pend_q;

  assert_trap_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q[$past(tid_i)]);

endmodule

// File: rtl/retire_counters.sv
module retire_counters #(
  parameter int CW    = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    insn_inc_i,
  input  logic [CW-1:0]    drop_inc_i,
  input  logic             full_i,
  output logic [CNT_W-1:0] insn_o,
  output logic [CNT_W-1:0] drop_o,
  output logic [CNT_W-1:0] bw_o
);

  logic [CNT_W-1:0] insn_q, drop_q, bw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q <= '0;
      drop_q <= '0;
      bw_q   <= '0;
    end else begin
      insn_q <= insn_q + CNT_W'(insn_inc_i);
      drop_q <= drop_q + CNT_W'(drop_inc_i);
      if (full_i) bw_q <= bw_q + CNT_W'(1);
    end
  end

  assign insn_o = insn_q;
  assign drop_o = drop_q;
  assign bw_o   = bw_q;

  assert_bw_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |=> bw_q == $past(bw_q) + CNT_W'(1));
  assert_bw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !full_i |=> $stable(bw_q));

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import retire_ctrl_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int THREADS = 2,
  parameter int SEQ_W   = 16,
  parameter int CNT_W   = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CW     = $clog2(WIDTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_valid_i,
  input  logic [TID_W-1:0]          sel_tid_i,
  input  logic                      stores_pending_i,
  input  logic [WIDTH-1:0]          head_valid_i,
  input  logic [WIDTH-1:0]          head_ready_i,
  input  logic [WIDTH*FLAG_W-1:0]   head_flags_i,
  input  logic [WIDTH*SEQ_W-1:0]    head_seq_i,
  input  logic [THREADS-1:0]        trap_clear_i,
  output logic [WIDTH-1:0]          retire_o,
  output logic [WIDTH-1:0]          commit_o,
  output logic [WIDTH-1:0]          canc_clr_o,
  output logic                      nonspec_req_o,
  output logic [SEQ_W-1:0]          nonspec_seq_o,
  output logic                      uncached_req_o,
  output logic [SEQ_W-1:0]          uncached_seq_o,
  output logic                      trap_req_o,
  output logic [TID_W-1:0]          trap_tid_o,
  output logic                      bad_head_o,
  output logic [THREADS-1:0]        trap_pending_o,
  output logic [CNT_W-1:0]          insn_count_o,
  output logic [CNT_W-1:0]          squash_count_o,
  output logic [CNT_W-1:0]          bwlimit_count_o
);

  function automatic logic [CW-1:0] popcount(input logic [WIDTH-1:0] v);
    logic [CW-1:0] n = '0;
    for (int k = 0; k < WIDTH; k++) n = n + CW'(v[k]);
    return n;
  endfunction

  logic               live  [WIDTH+1];
  logic [CW-1:0]      used  [WIDTH+1];
  slot_act_e          act   [WIDTH];
  logic [WIDTH-1:0]   tally;
  logic [WIDTH-1:0]   dropped;
  logic               thread_blocked;
  logic               full_cycle;

  assign thread_blocked = (int'(sel_tid_i) < THREADS) ? trap_pending_o[sel_tid_i] : 1'b1;
  assign live[0] = sel_valid_i && !thread_blocked;
  assign used[0] = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slot
    retire_slot_decide #(.CW(CW)) u_decide (
      .live_i  (live[i]),
      .valid_i (head_valid_i[i]),
      .ready_i (head_ready_i[i]),
      .flags_i (head_flags_t'(head_flags_i[i*FLAG_W +: FLAG_W])),
      .used_i  (used[i]),
      .stores_i(stores_pending_i),
      .act_o   (act[i]),
      .tally_o (tally[i]),
      .live_o  (live[i+1]),
      .used_o  (used[i+1])
    );
  end

  always_comb begin
    retire_o       = '0;
    commit_o       = '0;
    canc_clr_o     = '0;
    dropped        = '0;
    nonspec_req_o  = 1'b0;
    nonspec_seq_o  = '0;
    uncached_req_o = 1'b0;
    uncached_seq_o = '0;
    trap_req_o     = 1'b0;
    bad_head_o     = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      unique case (act[i])
        ACT_COMMIT: begin
          retire_o[i] = 1'b1;
          commit_o[i] = 1'b1;
        end
        ACT_DROP: begin
          retire_o[i] = 1'b1;
          dropped[i]  = 1'b1;
        end
        ACT_NONSPEC: begin
          nonspec_req_o = 1'b1;
          nonspec_seq_o = head_seq_i[i*SEQ_W +: SEQ_W];
          canc_clr_o[i] = 1'b1;
        end
        ACT_UNCACHED: begin
          uncached_req_o = 1'b1;
          uncached_seq_o = head_seq_i[i*SEQ_W +: SEQ_W];
          canc_clr_o[i]  = 1'b1;
        end
        ACT_TRAP: trap_req_o = 1'b1;
        ACT_BAD:  bad_head_o = 1'b1;
        default: ;
      endcase
    end
  end

  assign trap_tid_o = sel_tid_i;
  assign full_cycle = (used[WIDTH] == CW'(WIDTH));

  retire_trap_state #(.THREADS(THREADS), .TID_W(TID_W)) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (trap_req_o),
    .tid_i    (sel_tid_i),
    .clear_i  (trap_clear_i),
    .pending_o(trap_pending_o)
  );

  retire_counters #(.CW(CW), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_inc_i(popcount(tally)),
    .drop_inc_i(popcount(dropped)),
    .full_i    (full_cycle),
    .insn_o    (insn_count_o),
    .drop_o    (squash_count_o),
    .bw_o      (bwlimit_count_o)
  );

  assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nonspec_req_o, uncached_req_o, trap_req_o, bad_head_o}));
  assert_idle_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_i |-> (retire_o == '0 && !trap_req_o && !nonspec_req_o));
  assert_nonspec_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nonspec_req_o |-> (!stores_pending_i && commit_o == '0));
  assert_trap_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> (!stores_pending_i && commit_o == '0));
  assert_commit_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o & ~retire_o) == '0);
  assert_squash_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_o == '0) |=> $stable(squash_count_o));

endmodule

// File: tb/test_retire_ctrl.sv
module test_retire_ctrl;

  localparam int W = 4;
  localparam int T = 2;
  localparam int SW = 16;
  localparam int CNTW = 16;
  localparam int FW = 7;
  localparam logic [6:0] F_EXE = 7'h01, F_SQ = 7'h02, F_FLT = 7'h04,
                         F_NS = 7'h08, F_BAR = 7'h10, F_LD = 7'h20, F_NOP = 7'h40;

  logic clk = 0, rst_n = 0;
  logic sel_valid = 0, sel_tid = 0, stores = 0;
  logic [W-1:0] hvalid = '0, hready = '0;
  logic [W*FW-1:0] hflags = '0;
  logic [W*SW-1:0] hseq = '0;
  logic [T-1:0] tclear = '0;
  logic [W-1:0] retire, commit, cclr;
  logic ns_req, unc_req, trap_req, bad;
  logic [SW-1:0] ns_seq, unc_seq;
  logic trap_tid;
  logic [T-1:0] tpend;
  logic [CNTW-1:0] c_insn, c_sq, c_bw;

  always #10 clk = ~clk;

  retire_ctrl #(.WIDTH(W), .THREADS(T), .SEQ_W(SW), .CNT_W(CNTW)) i_retire_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_valid_i(sel_valid), .sel_tid_i(sel_tid),
    .stores_pending_i(stores), .head_valid_i(hvalid), .head_ready_i(hready),
    .head_flags_i(hflags), .head_seq_i(hseq), .trap_clear_i(tclear),
    .retire_o(retire), .commit_o(commit), .canc_clr_o(cclr),
    .nonspec_req_o(ns_req), .nonspec_seq_o(ns_seq),
    .uncached_req_o(unc_req), .uncached_seq_o(unc_seq),
    .trap_req_o(trap_req), .trap_tid_o(trap_tid), .bad_head_o(bad),
    .trap_pending_o(tpend), .insn_count_o(c_insn), .squash_count_o(c_sq),
    .bwlimit_count_o(c_bw));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_insn = 0, m_sq = 0, m_bw = 0;
  bit [T-1:0] m_pend = '0;
  bit [W-1:0] e_retire, e_commit, e_clr;
  bit e_ns, e_unc, e_trap, e_bad, e_full;
  int e_ns_seq, e_unc_seq, e_cnt, e_drop;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_slot(input int i, input bit v, input bit r, input logic [6:0] f, input int s);
    hvalid[i] = v;
    hready[i] = r;
    hflags[i*FW +: FW] = f;
    hseq[i*SW +: SW] = SW'(s);
  endtask

  task automatic fill_exec();
    for (int i = 0; i < W; i++) set_slot(i, 1, 1, F_EXE, 100 + i);
  endtask

  task automatic model_eval();
    int used = 0;
    bit go;
    logic [6:0] f;
    e_retire = '0; e_commit = '0; e_clr = '0;
    e_ns = 0; e_unc = 0; e_trap = 0; e_bad = 0;
    e_ns_seq = 0; e_unc_seq = 0; e_cnt = 0; e_drop = 0;
    go = sel_valid && !m_pend[sel_tid];
    for (int i = 0; i < W; i++) begin
      if (!go) break;
      f = hflags[i*FW +: FW];
      if (!hvalid[i] || !hready[i]) go = 0;
      else if ((f & F_SQ) != 0) begin e_retire[i] = 1; e_drop++; end
      else if ((f & F_EXE) == 0) begin
        go = 0;
        if ((f & (F_NS | F_BAR)) != 0) begin
          if (used == 0 && !stores) begin e_ns = 1; e_ns_seq = int'(hseq[i*SW +: SW]); e_clr[i] = 1; end
        end else if ((f & F_LD) != 0) begin
          e_unc = 1; e_unc_seq = int'(hseq[i*SW +: SW]); e_clr[i] = 1;
        end else e_bad = 1;
      end else if ((f & F_FLT) != 0) begin
        go = 0;
        if (used == 0 && !stores) e_trap = 1;
      end else begin
        e_retire[i] = 1; e_commit[i] = 1; used++;
        if ((f & F_NOP) == 0) e_cnt++;
      end
    end
    e_full = (used == W);
  endtask

  task automatic cycle(input string tag);
    #5;
    model_eval();
    chk({tag, " R1"}, "retire", retire, e_retire);
    chk({tag, " R3"}, "commit", commit, e_commit);
    chk({tag, " R4"}, "canc_clr", cclr, e_clr);
    chk({tag, " R4"}, "nonspec_req", ns_req, e_ns);
    if (e_ns) chk({tag, " R4"}, "nonspec_seq", ns_seq, e_ns_seq);
    chk({tag, " R5"}, "uncached_req", unc_req, e_unc);
    if (e_unc) chk({tag, " R5"}, "uncached_seq", unc_seq, e_unc_seq);
    chk({tag, " R6"}, "trap_req", trap_req, e_trap);
    chk({tag, " R6"}, "trap_pending", tpend, m_pend);
    chk({tag, " R7"}, "bad_head", bad, e_bad);
    chk({tag, " R3"}, "insn_count", c_insn, m_insn & 16'hFFFF);
    chk({tag, " R2"}, "squash_count", c_sq, m_sq & 16'hFFFF);
    chk({tag, " R8"}, "bwlimit_count", c_bw, m_bw & 16'hFFFF);
    @(posedge clk);
    m_insn += e_cnt;
    m_sq += e_drop;
    if (e_full) m_bw++;
    m_pend = m_pend & ~tclear;
    if (e_trap) m_pend[sel_tid] = 1;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9: reset state
    chk("R9", "insn_count", c_insn, 0);
    chk("R9", "squash_count", c_sq, 0);
    chk("R9", "bwlimit_count", c_bw, 0);
    chk("R9", "trap_pending", tpend, 0);

    sel_valid = 1; fill_exec();
    cycle("full width R8");
    sel_valid = 0;
    cycle("unselected R1");
    sel_valid = 1; fill_exec(); set_slot(2, 1, 0, F_EXE, 102);
    cycle("not-ready stop R1");
    fill_exec(); set_slot(1, 0, 1, F_EXE, 101);
    cycle("invalid stop R1");
    fill_exec(); set_slot(0, 1, 1, F_SQ, 100);
    cycle("squash drop R2");
    fill_exec(); set_slot(1, 1, 1, F_EXE | F_NOP, 101);
    cycle("nop R3");
    fill_exec(); set_slot(0, 1, 1, F_NS, 200);
    cycle("nonspec slot0 R4");
    fill_exec(); set_slot(1, 1, 1, F_NS, 201);
    cycle("nonspec slot1 R4");
    fill_exec(); set_slot(0, 1, 1, F_BAR, 202); stores = 1;
    cycle("barrier stores R4");
    stores = 0;
    fill_exec(); set_slot(0, 1, 1, F_SQ, 100); set_slot(1, 1, 1, F_NS, 203);
    cycle("squash then nonspec R2 R4");
    fill_exec(); set_slot(2, 1, 1, F_LD, 300); stores = 1;
    cycle("uncached load R5");
    stores = 0;
    fill_exec(); set_slot(1, 1, 1, F_EXE | F_FLT, 400);
    cycle("fault slot1 R6");
    fill_exec(); set_slot(0, 1, 1, F_EXE | F_FLT, 401);
    cycle("fault slot0 R6");
    fill_exec();
    cycle("trap blocks thread R6");
    sel_tid = 1;
    cycle("other thread runs R6");
    sel_tid = 0; tclear = 2'b01;
    cycle("clear trap R6");
    tclear = '0;
    fill_exec(); set_slot(0, 1, 1, 7'h00, 500);
    cycle("unknown head R7");
    fill_exec(); set_slot(1, 1, 1, F_LD | F_NS, 501);
    cycle("nonspec load R4");

    // random stream
    for (int n = 0; n < 3000; n++) begin
      sel_valid = ($urandom_range(0, 9) != 0);
      sel_tid = $urandom_range(0, 1);
      stores = ($urandom_range(0, 3) == 0);
      tclear = ($urandom_range(0, 4) == 0) ? T'($urandom_range(1, 3)) : '0;
      for (int i = 0; i < W; i++) begin
        int k = $urandom_range(0, 11);
        logic [6:0] f;
        case (k)
          0: f = F_SQ;
          1: f = F_NS;
          2: f = F_BAR;
          3: f = F_LD;
          4: f = F_EXE | F_FLT;
          5: f = F_EXE | F_NOP;
          6: f = 7'h00;
          default: f = F_EXE;
        endcase
        set_slot(i, $urandom_range(0, 15) != 0, $urandom_range(0, 9) != 0, f, int'($urandom_range(0, 65535)));
      end
      cycle("random R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule